// File: doc/BRIEF.md
# Flash Command Sequence Mode Controller

This block is the command-decoding state machine of a parallel NOR flash device. The host issues bus write cycles through active-low chip-enable and write-enable strobes, with an address and a data byte. The block brings these strobes into its own clock domain, rebuilds each write cycle, and matches the writes against the unlock-and-command patterns. From these it tracks the device mode. The modes are array read, identification (autoselect), program busy, erase busy, erase suspended, program inside an erase suspend, and fault.

The block drives single-cycle pulses to an abstract program/erase engine: start program, start erase, suspend and resume. It then follows that engine's completion and error flags. For every read address it also reports whether the read path must return array data, status data or identification data. In erase-suspend mode it keeps one bit per sector so that reads of suspended sectors return status.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (array read), no pulse is active, and rd_sel_o is 0 (array data) for every address, so a plain read needs no command.
- R2: A write cycle takes its address at the moment the later of the two enables falls (both low). Address changes after that point within the same cycle do not affect it.
- R3: A write cycle takes its data at the moment the first of the two enables rises. Data values present earlier in the cycle do not affect it.
- R4: The unlock pair is offset 0x555 with data 0xAA, then offset 0x2AA with data 0x55. The offset is the address below the top 3 sector bits. A wrong address or data, or a write out of order, returns the sequencer to idle with the mode unchanged.
- R5: Unlock, then 0xA0 at 0x555, then one data write gives one start_pgm_o pulse and mode 2 (program busy). The read source is status (rd_sel_o=1). Other writes are ignored. done_i returns the mode to 0.
- R6: Unlock, 0x80 at 0x555, unlock again, then 0x30 at any address gives one start_erase_o pulse and mode 3 (erase busy). It also marks the sector given by address bits [15:13]. done_i returns the mode to 0 and clears all marks.
- R7: In mode 3, a write of 0xB0 gives one suspend_o pulse and mode 4 (erase suspended). Reads in a marked sector return status (1); reads in all other sectors return array data (0).
- R8: In mode 4, a lone write of 0x30 with the sequencer idle gives one resume_o pulse and mode 3.
- R9: In mode 4, the program sequence gives a start_pgm_o pulse and mode 5, with status reads. done_i returns the mode to 4, with the same per-sector read behaviour as before.
- R10: err_i in modes 2, 3 or 5 gives mode 6 (fault) with status reads. Only a write of 0xF0 leaves it, to mode 0.
- R11: Unlock, then 0x90 at 0x555 gives mode 1 (identification), with rd_sel_o=2. Only a write of 0xF0 leaves it, to mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable from the bus, active low, asynchronous |
| we_ni | input | 1 | Write enable from the bus, active low, asynchronous |
| addr_i | input | 16 | Bus address, used for writes and for read-source selection |
| data_i | input | 8 | Bus write data |
| done_i | input | 1 | Engine finished the current operation |
| err_i | input | 1 | Engine reports a timeout/failure |
| mode_o | output | 3 | Device mode: 0 array, 1 ident, 2 program, 3 erase, 4 suspended, 5 program in suspend, 6 fault |
| rd_sel_o | output | 2 | Read source: 0 array, 1 status, 2 identification |
| start_pgm_o | output | 1 | One-cycle program start pulse |
| start_erase_o | output | 1 | One-cycle erase start pulse |
| suspend_o | output | 1 | One-cycle erase suspend pulse |
| resume_o | output | 1 | One-cycle erase resume pulse |

## Verification
A write takes effect four clock edges after its first enable rises: two synchronizer stages, one edge-detect register and the sequencer register. The bench therefore holds each write idle for five cycles before it compares mode_o and the pulse counters. An engine flag moves mode_o on the next edge, and the sector marks follow the start pulse one edge later. Both settle within the two idle cycles the bench leaves after each flag. rd_sel_o is combinational in the read address, so the bench sets addr_i at a falling edge and samples it one time unit later.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    MD_ARRAY    = 3'd0,
    MD_IDENT    = 3'd1,
    MD_PGM      = 3'd2,
    MD_ERS      = 3'd3,
    MD_SUSP     = 3'd4,
    MD_SUSP_PGM = 3'd5,
    MD_FAULT    = 3'd6
  } mode_e;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_IDENT  = 2'd2
  } rd_src_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM_DATA, SQ_E1, SQ_EU1, SQ_EU2
  } seq_e;

  localparam int unsigned UNLOCK_A1 = 'h555;
  localparam int unsigned UNLOCK_A2 = 'h2AA;
  localparam logic [7:0] UNLOCK_D1   = 8'hAA;
  localparam logic [7:0] UNLOCK_D2   = 8'h55;
  localparam logic [7:0] CMD_PGM     = 8'hA0;
  localparam logic [7:0] CMD_ERS_SET = 8'h80;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM = 8'h30;
  localparam logic [7:0] CMD_RESET   = 8'hF0;

endpackage

// File: rtl/fcc_bus_sync.sv
module fcc_bus_sync #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_vld_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);

  logic [STAGES-1:0] ce_sr, we_sr;
  logic act, act_q, wr_vld_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_sr <= '1;
      we_sr <= '1;
    end else begin
      ce_sr <= {ce_sr[STAGES-2:0], ce_ni};
      we_sr <= {we_sr[STAGES-2:0], we_ni};
    end
  end

  // write cycle active only while both synchronized enables are low
  assign act = ~ce_sr[STAGES-1] & ~we_sr[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      wr_vld_q <= 1'b0;
    end else begin
      act_q    <= act;
      wr_vld_q <= ~act & act_q;
      if (act & ~act_q) addr_q <= addr_i;
      if (~act & act_q) data_q <= data_i;
    end
  end

  assign wr_vld_o  = wr_vld_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;

  AST_WR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_q |=> !wr_vld_q); // R3
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && act_q) |=> $stable(addr_q)); // R2

endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SB = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_vld_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          done_i,
  input  logic          err_i,
  output mode_e         mode_o,
  output logic          start_pgm_o,
  output logic          start_erase_o,
  output logic          suspend_o,
  output logic          resume_o,
  output logic [SB-1:0] ers_sect_o,
  output logic          clr_marks_o
);

  localparam int OW = AW - SB;

  mode_e mode_q, mode_d;
  seq_e  seq_q, seq_d;
  logic  pgm_d, ers_d, sus_d, res_d;
  logic  pgm_q, ers_q, sus_q, res_q, clr_q;
  logic [SB-1:0] sect_q;
  logic [OW-1:0] off;
  logic busy, is_u1, is_u2, at_u1;

  assign off   = wr_addr_i[OW-1:0];
  assign at_u1 = off == OW'(UNLOCK_A1);
  assign is_u1 = at_u1 && wr_data_i == DW'(UNLOCK_D1);
  assign is_u2 = off == OW'(UNLOCK_A2) && wr_data_i == DW'(UNLOCK_D2);
  assign busy  = mode_q inside {MD_PGM, MD_ERS, MD_SUSP_PGM};

  always_comb begin
    mode_d = mode_q;
    seq_d  = seq_q;
    pgm_d  = 1'b0;
    ers_d  = 1'b0;
    sus_d  = 1'b0;
    res_d  = 1'b0;
    if (busy && err_i) begin
      mode_d = MD_FAULT;
      seq_d  = SQ_IDLE;
    end else if (busy && done_i) begin
      seq_d  = SQ_IDLE;
      mode_d = (mode_q == MD_SUSP_PGM) ? MD_SUSP : MD_ARRAY;
    end else if (wr_vld_i) begin
      unique case (mode_q)
        MD_FAULT, MD_IDENT: begin
          seq_d = SQ_IDLE;
          if (wr_data_i == DW'(CMD_RESET)) mode_d = MD_ARRAY;
        end
        MD_ERS: begin
          seq_d = SQ_IDLE;
          if (wr_data_i == DW'(CMD_SUSPEND)) begin
            mode_d = MD_SUSP;
            sus_d  = 1'b1;
          end
        end
        MD_ARRAY, MD_SUSP: begin
          if (seq_q == SQ_PGM_DATA) begin
            pgm_d  = 1'b1;
            mode_d = (mode_q == MD_ARRAY) ? MD_PGM : MD_SUSP_PGM;
            seq_d  = SQ_IDLE;
          end else if (wr_data_i == DW'(CMD_RESET)) begin
            seq_d = SQ_IDLE;
          end else if (mode_q == MD_SUSP && seq_q == SQ_IDLE &&
                       wr_data_i == DW'(CMD_CONFIRM)) begin
            res_d  = 1'b1;
            mode_d = MD_ERS;
          end else begin
            seq_d = SQ_IDLE;
            unique case (seq_q)
              SQ_IDLE: if (is_u1) seq_d = SQ_U1;
              SQ_U1:   if (is_u2) seq_d = SQ_U2;
              SQ_U2: if (at_u1) begin
                if (wr_data_i == DW'(CMD_PGM)) seq_d = SQ_PGM_DATA;
                else if (mode_q == MD_ARRAY && wr_data_i == DW'(CMD_ERS_SET)) seq_d = SQ_E1;
                else if (mode_q == MD_ARRAY && wr_data_i == DW'(CMD_IDENT)) mode_d = MD_IDENT;
              end
              SQ_E1:  if (is_u1) seq_d = SQ_EU1;
              SQ_EU1: if (is_u2) seq_d = SQ_EU2;
              SQ_EU2: if (wr_data_i == DW'(CMD_CONFIRM)) begin
                ers_d  = 1'b1;
                mode_d = MD_ERS;
              end
              default: seq_d = SQ_IDLE;
            endcase
          end
        end
        default: seq_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_ARRAY;
      seq_q  <= SQ_IDLE;
      pgm_q  <= 1'b0;
      ers_q  <= 1'b0;
      sus_q  <= 1'b0;
      res_q  <= 1'b0;
      clr_q  <= 1'b0;
      sect_q <= '0;
    end else begin
      mode_q <= mode_d;
      seq_q  <= seq_d;
      pgm_q  <= pgm_d;
      ers_q  <= ers_d;
      sus_q  <= sus_d;
      res_q  <= res_d;
      clr_q  <= (mode_d == MD_ARRAY) && (mode_q != MD_ARRAY);
      if (ers_d) sect_q <= wr_addr_i[AW-1 -: SB];
    end
  end

  assign mode_o        = mode_q;
  assign start_pgm_o   = pgm_q;
  assign start_erase_o = ers_q;
  assign suspend_o     = sus_q;
  assign resume_o      = res_q;
  assign ers_sect_o    = sect_q;
  assign clr_marks_o   = clr_q;

  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pgm_q, ers_q, sus_q, res_q})); // R6
  AST_PGM_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MD_PGM && done_i && !err_i) |=> mode_q == MD_ARRAY); // R5
  AST_SPGM_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MD_SUSP_PGM && done_i && !err_i) |=> mode_q == MD_SUSP); // R9
  AST_SUSP_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sus_q |-> mode_q == MD_SUSP); // R7
  AST_RESUME_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_q |-> mode_q == MD_ERS); // R8
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MD_FAULT && !(wr_vld_i && wr_data_i == DW'(CMD_RESET))) |=> mode_q == MD_FAULT); // R10
  AST_IDENT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MD_IDENT && !(wr_vld_i && wr_data_i == DW'(CMD_RESET))) |=> mode_q == MD_IDENT); // R11

endmodule

// File: rtl/fcc_sect_track.sv
module fcc_sect_track
  import flash_cmd_pkg::*;
#(
  parameter int SB = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [SB-1:0] set_idx_i,
  input  logic          clr_i,
  input  mode_e         mode_i,
  input  logic [SB-1:0] rd_sect_i,
  output rd_src_e       rd_sel_o
);

  localparam int NSECT = 1 << SB;

  logic [NSECT-1:0] marks_q, set_mask;

  for (genvar s = 0; s < NSECT; s++) begin : g_mask
    assign set_mask[s] = set_i && (set_idx_i == SB'(s));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     marks_q <= '0;
    else if (clr_i)  marks_q <= '0;
    else             marks_q <= marks_q | set_mask;
  end

  always_comb begin
    unique case (mode_i)
      MD_ARRAY: rd_sel_o = SRC_ARRAY;
      MD_IDENT: rd_sel_o = SRC_IDENT;
      MD_SUSP:  rd_sel_o = marks_q[rd_sect_i] ? SRC_STATUS : SRC_ARRAY;
      default:  rd_sel_o = SRC_STATUS;
    endcase
  end

  AST_MARKS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(marks_q)); // R6
  AST_MARKS_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> marks_q == '0); // R6

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SB = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          done_i,
  input  logic          err_i,
  output logic [2:0]    mode_o,
  output logic [1:0]    rd_sel_o,
  output logic          start_pgm_o,
  output logic          start_erase_o,
  output logic          suspend_o,
  output logic          resume_o
);

  logic          wr_vld, clr_marks;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [SB-1:0] ers_sect;
  mode_e         mode;
  rd_src_e       rd_sel;

  fcc_bus_sync #(.AW(AW), .DW(DW), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .addr_i, .data_i,
    .wr_vld_o(wr_vld), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  fcc_seq #(.AW(AW), .DW(DW), .SB(SB)) u_seq (
    .clk_i, .rst_ni,
    .wr_vld_i(wr_vld), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .done_i, .err_i,
    .mode_o(mode), .start_pgm_o, .start_erase_o, .suspend_o, .resume_o,
    .ers_sect_o(ers_sect), .clr_marks_o(clr_marks)
  );

  fcc_sect_track #(.SB(SB)) u_track (
    .clk_i, .rst_ni,
    .set_i(start_erase_o), .set_idx_i(ers_sect), .clr_i(clr_marks),
    .mode_i(mode), .rd_sect_i(addr_i[AW-1 -: SB]), .rd_sel_o(rd_sel)
  );

  assign mode_o   = mode;
  assign rd_sel_o = rd_sel;

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;

  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, done = 1'b0, err = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [2:0] mode;
  logic [1:0] rd_sel;
  logic s_pgm, s_ers, s_sus, s_res;

  flash_cmd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .addr_i(addr), .data_i(data),
    .done_i(done), .err_i(err), .mode_o(mode), .rd_sel_o(rd_sel),
    .start_pgm_o(s_pgm), .start_erase_o(s_ers), .suspend_o(s_sus), .resume_o(s_res)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int c_pgm = 0, c_ers = 0, c_sus = 0, c_res = 0;
  int e_pgm = 0, e_ers = 0, e_sus = 0, e_res = 0;
  int e_mode = 0, e_seq = 0;
  logic [7:0] e_marks = '0;
  bit fin = 0;

  always @(negedge clk) if (rst_n) begin
    if (s_pgm) c_pgm++;
    if (s_ers) c_ers++;
    if (s_sus) c_sus++;
    if (s_res) c_res++;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_sel(int sect);
    case (e_mode)
      0: return 0;
      1: return 2;
      4: return e_marks[sect] ? 1 : 0;
      default: return 1;
    endcase
  endfunction

  task automatic chk_all(string req);
    chk({req, " mode"}, int'(mode), e_mode);
    chk({req, " pgm pulses"}, c_pgm, e_pgm);
    chk({req, " erase pulses"}, c_ers, e_ers);
    chk({req, " suspend pulses"}, c_sus, e_sus);
    chk({req, " resume pulses"}, c_res, e_res);
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      addr = AW'(s << 13) | AW'($urandom % 8192);
      #1;
      chk({req, " read source"}, int'(rd_sel), exp_sel(s));
    end
  endtask

  // reference model of one completed write
  task automatic mdl_wr(int a, int d);
    int off = a & 'h1FFF;
    if (e_mode == 6 || e_mode == 1) begin
      e_seq = 0;
      if (d == 'hF0) begin e_mode = 0; e_marks = '0; end
    end else if (e_mode == 3) begin
      e_seq = 0;
      if (d == 'hB0) begin e_mode = 4; e_sus++; end
    end else if (e_mode == 0 || e_mode == 4) begin
      if (e_seq == 3) begin
        e_pgm++; e_mode = (e_mode == 0) ? 2 : 5; e_seq = 0;
      end else if (d == 'hF0) e_seq = 0;
      else if (e_mode == 4 && e_seq == 0 && d == 'h30) begin
        e_res++; e_mode = 3;
      end else begin
        case (e_seq)
          0: e_seq = (off == 'h555 && d == 'hAA) ? 1 : 0;
          1: e_seq = (off == 'h2AA && d == 'h55) ? 2 : 0;
          2: begin
            e_seq = 0;
            if (off == 'h555) begin
              if (d == 'hA0) e_seq = 3;
              else if (d == 'h80 && e_mode == 0) e_seq = 4;
              else if (d == 'h90 && e_mode == 0) e_mode = 1;
            end
          end
          4: e_seq = (off == 'h555 && d == 'hAA) ? 5 : 0;
          5: e_seq = (off == 'h2AA && d == 'h55) ? 6 : 0;
          6: begin
            e_seq = 0;
            if (d == 'h30) begin e_ers++; e_mode = 3; e_marks[(a >> 13) & 7] = 1'b1; end
          end
          default: e_seq = 0;
        endcase
      end
    end else e_seq = 0;
  endtask

  task automatic bus_write(int a, int d);
    @(negedge clk);
    addr = AW'(a); data = DW'(d); ce_n = 0; we_n = 0;
    repeat (4) @(negedge clk);
    ce_n = 1; we_n = 1;
    repeat (5) @(negedge clk);
    mdl_wr(a, d);
  endtask

  task automatic engine(bit is_err);
    @(negedge clk);
    if (is_err) err = 1; else done = 1;
    @(negedge clk);
    err = 0; done = 0;
    repeat (2) @(negedge clk);
    if (e_mode == 2 || e_mode == 3 || e_mode == 5) begin
      if (is_err) e_mode = 6;
      else if (e_mode == 5) e_mode = 4;
      else begin e_mode = 0; e_marks = '0; end
      e_seq = 0;
    end
  endtask

  task automatic unlock();
    bus_write('h555, 'hAA);
    bus_write('h2AA, 'h55);
  endtask

  task automatic rand_op();
    int r = int'($urandom % 100);
    int a, d;
    if ((e_mode == 2 || e_mode == 3 || e_mode == 5) && r < 40) begin
      engine(r < 4);
      return;
    end
    if (r < 65) begin
      a = int'($urandom % 65536) & 'hE000;
      case (e_seq)
        0, 4: begin
          if (e_mode == 3) d = 'hB0;
          else if (e_mode == 6 || e_mode == 1) d = 'hF0;
          else if (e_mode == 4 && r < 20) d = 'h30;
          else begin a = a | 'h555; d = 'hAA; end
        end
        1, 5: begin a = a | 'h2AA; d = 'h55; end
        2: begin
          a = a | 'h555;
          case ($urandom % 3) 0: d = 'hA0; 1: d = 'h80; default: d = 'h90; endcase
        end
        6: d = 'h30;
        default: d = int'($urandom % 256);
      endcase
    end else begin
      case ($urandom % 3) 0: a = 'h555; 1: a = 'h2AA; default: a = int'($urandom % 8192); endcase
      a = a | (int'($urandom % 8) << 13);
      case ($urandom % 6)
        0: d = 'hAA; 1: d = 'h55; 2: d = 'hF0; 3: d = 'h30; 4: d = 'hB0;
        default: d = int'($urandom % 256);
      endcase
    end
    bus_write(a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk_all("R1 reset");

    // R11 identification, other sequences ignored, reset leaves
    unlock(); bus_write('h555, 'h90);
    chk_all("R11 enter");
    unlock(); bus_write('h555, 'hA0); bus_write('h0100, 'h12);
    chk_all("R11 ignore");
    bus_write('h0000, 'hF0);
    chk_all("R11 exit");

    // R4 malformed and out of order
    bus_write('h555, 'hAA); bus_write('h2AA, 'h56); bus_write('h555, 'h90);
    chk_all("R4 bad data");
    bus_write('h2AA, 'h55); bus_write('h555, 'hAA); bus_write('h555, 'h90);
    chk_all("R4 out of order");
    bus_write('h555, 'hAA); bus_write('h2AB, 'h55); bus_write('h555, 'h80);
    chk_all("R4 bad address");

    // R5 program
    unlock(); bus_write('h555, 'hA0); bus_write('h4321, 'h5A);
    chk_all("R5 busy");
    bus_write('h0000, 'hB0);
    chk_all("R5 ignore");
    engine(0);
    chk_all("R5 done");

    // R6 erase sector 5
    unlock(); bus_write('h555, 'h80); unlock(); bus_write('hA000, 'h30);
    chk_all("R6 busy");
    engine(0);
    chk_all("R6 done");

    // R7 suspend, R9 program inside, R8 resume
    unlock(); bus_write('h555, 'h80); unlock(); bus_write('h4000, 'h30);
    bus_write('h1234, 'hB0);
    chk_all("R7 suspended");
    unlock(); bus_write('h555, 'hA0); bus_write('hE010, 'h77);
    chk_all("R9 program in suspend");
    engine(0);
    chk_all("R9 back to suspend");
    bus_write('h0000, 'h30);
    chk_all("R8 resumed");
    engine(0);
    chk_all("R8 done");

    // R10 fault
    unlock(); bus_write('h555, 'hA0); bus_write('h0010, 'h01);
    engine(1);
    chk_all("R10 fault");
    unlock(); bus_write('h555, 'h90);
    chk_all("R10 sticky");
    bus_write('h0000, 'hF0);
    chk_all("R10 exit");

    // R2 address taken when the later enable falls
    @(negedge clk);
    addr = 'h0AAA; data = 'hAA; we_n = 0;
    repeat (3) @(negedge clk);
    addr = 'h0555; ce_n = 0;
    repeat (4) @(negedge clk);
    addr = 'h0123;
    repeat (2) @(negedge clk);
    ce_n = 1; we_n = 1;
    repeat (5) @(negedge clk);
    mdl_wr('h555, 'hAA);
    bus_write('h2AA, 'h55); bus_write('h555, 'h90);
    chk_all("R2 address capture");
    bus_write('h0000, 'hF0);

    // R3 data taken when the first enable rises
    bus_write('h555, 'hAA);
    @(negedge clk);
    addr = 'h02AA; data = 'h00; ce_n = 0; we_n = 0;
    repeat (3) @(negedge clk);
    data = 'h55;
    repeat (2) @(negedge clk);
    ce_n = 1;
    repeat (4) @(negedge clk);
    we_n = 1;
    repeat (5) @(negedge clk);
    data = 'h00;
    mdl_wr('h2AA, 'h55);
    bus_write('h555, 'h90);
    chk_all("R3 data capture");
    bus_write('h0000, 'hF0);

    // R4 random mix with the model
    for (int i = 0; i < 300; i++) begin
      rand_op();
      chk("R4 random mode", int'(mode), e_mode);
      if (i % 25 == 24) chk_all("R4 random");
    end

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule